// File: doc/BRIEF.md
# Double-to-Single Float Narrower

This block takes a 64-bit IEEE binary64 bit pattern and returns a 32-bit binary32 bit pattern. It does the conversion by picking bits out of the input, and it never rounds. An input whose biased exponent is above 896 is mapped field by field. So is an input that is a signed zero. The top exponent bit is kept, the low seven exponent bits are kept, and the fraction is cut to its upper 23 bits.

An input with a biased exponent from 874 to 896 becomes a single-precision denormal. The block puts the implicit leading one back in front of the fraction. It then shifts the result right by 897 minus the exponent, which is 1 to 23 places. Bits that fall off the end are discarded. Every other input gives an all-zero word.

The block is used as a one-stage pipeline. A word presented with `in_valid` high comes out registered on the next clock with `out_valid` high. While the input is idle, the output register keeps its last value.

Top module: `f64_to_f32_narrow`

## Requirements
Bit indices below are little-endian. Input bit 63 is the sign, bits 62:52 the biased exponent E and bits 51:0 the fraction. Output bit 31 is the sign, bits 30:23 the exponent and bits 22:0 the fraction.
- R1: While `rst` is high at a clock edge, `out_valid` and `out_word` are 0 after that edge.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge.
- R3: When E > 896, the output is {in[63], in[62], in[58:29]}. This includes E = 2047.
- R4: When in[62:0] is zero, the output is {in[63], 31'b0}.
- R5: When 874 <= E <= 896, the output sign is in[63] and the output exponent is 0. The output fraction is bits 51:29 of ({1'b1, in[51:0]} >> (897 - E)), truncated.
- R6: When 1 <= E <= 873, or when E = 0 with a nonzero fraction, the output is all zeros, sign included.
- R7: While `in_valid` is low, `out_word` keeps its previous value.
- R8: At E = 896 the output fraction bit 22 is 1. At E = 874 the output fraction is exactly 1, whatever the input fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_word | input | 64 | binary64 bit pattern |
| out_valid | output | 1 | Output word is valid, one cycle after input |
| out_word | output | 32 | binary32 bit pattern |

## Verification
The assertions check on every cycle:
- the one-cycle valid latency and hold behaviour;
- the direct field mapping;
- the signed-zero and all-zero classes;
- the zero exponent and copied sign of denormals;
- the two denormal shift endpoints.

The exact truncated fraction of every intermediate denormal shift is not covered by the assertions. Only the bench shows it, by sweeping every exponent with both signs and several fraction patterns against an arithmetic model that shifts one place per step.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
    localparam int WIDE_W   = 64;
    localparam int NARROW_W = 32;
    localparam int WEXP_W   = 11;
    localparam int WFRAC_W  = 52;
    localparam int NEXP_W   = 8;
    localparam int NFRAC_W  = 23;
    localparam int WBIAS    = 1023;
    localparam int NBIAS    = 127;
    localparam int SIG_W    = WFRAC_W + 1;
    localparam int DROP_W   = WFRAC_W - NFRAC_W;
    localparam int NMIN_UNB = 1 - NBIAS;
    localparam int DEN_HI   = WBIAS + NMIN_UNB - 1;
    localparam int DEN_LO   = DEN_HI - NFRAC_W + 1;
    localparam int SHIFT_W  = $clog2(NFRAC_W + 1);

    typedef enum logic [1:0] {
        CLS_DIRECT = 2'd0,
        CLS_DENORM = 2'd1,
        CLS_ZERO   = 2'd2
    } cls_e;

    typedef struct packed {
        logic               sign;
        logic [WEXP_W-1:0]  exp;
        logic [WFRAC_W-1:0] frac;
    } wide_t;

    typedef struct packed {
        logic               sign;
        logic [NEXP_W-1:0]  exp;
        logic [NFRAC_W-1:0] frac;
    } narrow_t;

    function automatic logic [SHIFT_W-1:0] denorm_shift(input logic [WEXP_W-1:0] e);
        logic [WEXP_W:0] diff;
        diff = (WEXP_W+1)'(DEN_HI + 1) - {1'b0, e};
        return diff[SHIFT_W-1:0];
    endfunction
endpackage

// File: rtl/narrow_classify.sv
module narrow_classify
    import narrow_pkg::*;
(
    input  wide_t w,
    output cls_e  cls
);
    logic rest_zero;
    logic above;
    logic in_band;

    always_comb begin
        rest_zero = ({w.exp, w.frac} == '0);
        above     = ({1'b0, w.exp} > (WEXP_W+1)'(DEN_HI));
        in_band   = ({1'b0, w.exp} >= (WEXP_W+1)'(DEN_LO)) && !above;
        if (above || rest_zero)
            cls = CLS_DIRECT;
        else if (in_band)
            cls = CLS_DENORM;
        else
            cls = CLS_ZERO;
    end
endmodule

// File: rtl/narrow_direct.sv
module narrow_direct
    import narrow_pkg::*;
(
    input  wide_t   w,
    output narrow_t n
);
    always_comb begin
        n.sign = w.sign;
        n.exp  = {w.exp[WEXP_W-1], w.exp[NEXP_W-2:0]};
        n.frac = w.frac[WFRAC_W-1 -: NFRAC_W];
    end
endmodule

// File: rtl/narrow_denorm.sv
module narrow_denorm
    import narrow_pkg::*;
(
    input  wide_t   w,
    output narrow_t n
);
    logic [SHIFT_W-1:0] sh;
    logic [SIG_W-1:0]   sig;
    logic [SIG_W-1:0]   shifted;

    always_comb begin
        sh      = denorm_shift(w.exp);
        sig     = {1'b1, w.frac};
        shifted = sig >> sh;
        n.sign  = w.sign;
        n.exp   = '0;
        n.frac  = shifted[WFRAC_W-1 -: NFRAC_W];
    end
endmodule

// File: rtl/f64_to_f32_narrow.sv
module f64_to_f32_narrow
    import narrow_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WIDE_W-1:0]   in_word,
    output logic                out_valid,
    output logic [NARROW_W-1:0] out_word
);
    wide_t   w;
    cls_e    cls;
    narrow_t n_direct;
    narrow_t n_denorm;
    narrow_t n_sel;

    assign w = wide_t'(in_word);

    narrow_classify u_cls (.w(w), .cls(cls));
    narrow_direct   u_dir (.w(w), .n(n_direct));
    narrow_denorm   u_den (.w(w), .n(n_denorm));

    always_comb begin
        unique case (cls)
            CLS_DIRECT: n_sel = n_direct;
            CLS_DENORM: n_sel = n_denorm;
            default:    n_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_word <= n_sel;
        end
    end
endmodule

// File: rtl/narrow_chk.sv
module narrow_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_word,
    input logic        out_valid,
    input logic [31:0] out_word
);
    logic [10:0] ex;
    assign ex = in_word[62:52];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == 32'h0)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid))); // R2

    AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex > 11'd896) |=>
        (out_word == {$past(in_word[63]), $past(in_word[62]), $past(in_word[58:29])})); // R3

    AST_SIGNED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[62:0] == 63'h0) |=>
        (out_word == {$past(in_word[63]), 31'h0})); // R4

    AST_DENORM_EXP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex >= 11'd874 && ex <= 11'd896) |=>
        (out_word[30:23] == 8'h0 && out_word[31] == $past(in_word[63]))); // R5

    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex <= 11'd873 && in_word[62:0] != 63'h0) |=>
        (out_word == 32'h0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> $stable(out_word)); // R7

    AST_BAND_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex == 11'd896) |=> out_word[22]); // R8

    AST_BAND_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ex == 11'd874) |=> (out_word[22:0] == 23'h1)); // R8
endmodule

bind f64_to_f32_narrow narrow_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word)
);

// File: tb/f64_to_f32_narrow_tb.sv
`timescale 1ns/1ps
module f64_to_f32_narrow_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = 64'h0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    f64_to_f32_narrow u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_word(out_word)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] model(input logic [63:0] x);
        int e = int'(x[62:52]);
        logic [52:0] s;
        int ue;
        if (e > 896 || x[62:0] == 63'h0)
            return {x[63], x[62], x[58:29]};
        if (e >= 874 && e <= 896) begin
            s  = {1'b1, x[51:0]};
            ue = e - 1023;
            while (ue < -126) begin
                s = s >> 1;
                ue++;
            end
            return {x[63], 8'h00, s[51:29]};
        end
        return 32'h0;
    endfunction

    function automatic string req_of(input logic [63:0] x);
        int e = int'(x[62:52]);
        if (x[62:0] == 63'h0) return "R4";
        if (e > 896) return "R3";
        if (e == 896 || e == 874) return "R8/R5";
        if (e >= 874) return "R5";
        return "R6";
    endfunction

    task automatic apply(input logic [63:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = x;
        @(posedge clk);
        #1;
        check("R2 valid", {31'h0, out_valid}, 32'h1);
        check(req_of(x), out_word, model(x));
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [51:0] fr [4];
        logic [31:0] held;
        fr[0] = 52'h0;
        fr[1] = 52'hF_FFFF_FFFF_FFFF;
        fr[2] = 52'h5_5555_5555_5555;
        fr[3] = 52'h8_0000_2000_0001;

        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {31'h0, out_valid}, 32'h0);
        check("R1 word", out_word, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 2048; e++)
                for (int f = 0; f < 4; f++)
                    apply({s[0], e[10:0], fr[f]});

        apply(64'h3810_0000_0000_0000);
        check("R8 smallest normal", out_word, 32'h0080_0000);
        apply({1'b0, 11'd874, 52'hF_FFFF_FFFF_FFFF});
        check("R8 bottom of band", out_word, 32'h0000_0001);
        apply({1'b1, 11'd896, 52'h0});
        check("R8 top of band", out_word, 32'h8040_0000);

        held = out_word;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 64'h4000_0000_0000_0000;
        @(posedge clk);
        #1;
        check("R2 idle valid", {31'h0, out_valid}, 32'h0);
        check("R7 hold", out_word, held);
        @(posedge clk);
        #1;
        check("R7 hold again", out_word, held);

        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset again", out_word, 32'h0);
        check("R1 valid again", {31'h0, out_valid}, 32'h0);
        report();
    end
endmodule